// File: doc/BRIEF.md
# System Control Register File with GPIO Output Bank and Interrupt Combiner

This block is the control register file of a multi-function I/O companion device. A host reaches it through a bus that moves one byte per access. It holds a fixed revision byte and an interrupt status and mask pair. The status register follows eight level-sensitive sub-function interrupt lines: line 0 is the flash controller, 1 the card slot, 2 the USB host, 3 the serial port and 4 the display. The pair is reduced to a single interrupt output. It also holds clock and PLL setting registers, which are only storage.

The block drives a bank of 16 general-purpose output pins. Each pin has a data bit and an output-enable bit. The level on a pin is the data bit ANDed with the enable bit. Whenever a write makes that level change, the block raises a one-cycle change strobe for the pin, and the new level appears on the level output. Registers wider than a byte sit at consecutive addresses, with the least significant byte at the lowest address. Each byte lane is written on its own.

Top module: `sysctl_regs`

## Requirements
- R1: While reset is held, and on the first cycles after it is released, the pin levels and change strobes are 0 and the interrupt output is low. The mask, data and output-enable registers read 0.
- R2: Offset 0x08 reads the revision parameter (default 0x03). Writes to it have no effect.
- R3: The status byte at 0x50 reads the sub-interrupt inputs as sampled on the previous clock edge, with bit i = line i. Writes to it have no effect.
- R4: The mask byte at 0x52 is read/write. The interrupt output is high exactly when the status ANDed with the mask is nonzero.
- R5: Data bytes sit at 0x78, 0x79 and 0x7A, and output-enable bytes at 0x7C, 0x7D and 0x7E. Byte k covers pins 8k to 8k+7, LSB first. All six bytes read back the value last written.
- R6: Pin level i equals data bit i ANDed with enable bit i. Bits 16 and up (bytes 0x7A and 0x7E) never reach the pin outputs.
- R7: In the cycle after a write edge to a data or enable byte, change strobe i is high exactly when the level of pin i differs from its level before that write. In every other cycle, all strobes are 0.
- R8: The clock register (0x98-0x99) and PLL2 register (0x9A-0x9B) are 16 bits wide, and the PLL1 register (0x9C-0x9F) is 32 bits wide. A byte write replaces only its own lane.
- R9: Reads of unmapped offsets return 0. Writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Byte access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, combinational, 0 when not reading |
| sub_irq | input | 8 | Level-sensitive sub-function interrupt lines |
| irq_out | output | 1 | Combined interrupt |
| gpio_level | output | 16 | Driven pin levels |
| gpio_chg | output | 16 | Per-pin one-cycle change strobe |

## Verification
The assertions take for granted that the bus inputs and the sub-interrupt lines are driven to known values from the first cycle, and that they change only between clock edges. The bench drives every input on the falling edge, keeps the strobe low outside a task, and holds each access for exactly one rising edge. So every register update and every change strobe lines up with a single write. Checks wait for the two-cycle reset release before looking at any output.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam logic [7:0] OFS_REV   = 8'h08;
  localparam logic [7:0] OFS_STAT  = 8'h50;
  localparam logic [7:0] OFS_MASK  = 8'h52;
  localparam logic [7:0] OFS_DATA  = 8'h78;
  localparam logic [7:0] OFS_OE    = 8'h7C;
  localparam logic [7:0] OFS_CLK   = 8'h98;
  localparam logic [7:0] OFS_PLL2  = 8'h9A;
  localparam logic [7:0] OFS_PLL1  = 8'h9C;
  localparam int unsigned CLK_BYTES  = 2;
  localparam int unsigned PLL2_BYTES = 2;
  localparam int unsigned PLL1_BYTES = 4;
endpackage

// File: rtl/sysctl_rstsync.sv
module sysctl_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/sysctl_lanereg.sv
module sysctl_lanereg #(
  parameter int unsigned BYTES = 2,
  parameter logic [7:0]  BASE  = 8'h98
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic       rd,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       hit
);
  localparam int unsigned W = BYTES * 8;

  logic [W-1:0] val_q, val_d;
  logic         wr_hit;

  always_comb begin
    val_d  = val_q;
    rdata  = 8'h00;
    hit    = 1'b0;
    for (int i = 0; i < BYTES; i++) begin
      if (addr == 8'(BASE + 8'(i))) begin
        hit = 1'b1;
        if (we) val_d[i*8 +: 8] = wdata;
        if (rd) rdata = val_q[i*8 +: 8];
      end
    end
  end

  assign wr_hit = we & hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      val_q <= '0;
    else if (wr_hit) val_q <= val_d;
  end

  p_lane_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_hit) |-> $stable(val_q));
endmodule

// File: rtl/sysctl_irq.sv
module sysctl_irq
  import sysctl_pkg::*;
#(
  parameter int unsigned NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic            rd,
  input  logic [7:0]      addr,
  input  logic [7:0]      wdata,
  input  logic [NSRC-1:0] sub_irq,
  output logic [7:0]      rdata,
  output logic            hit,
  output logic            irq_out
);
  logic [NSRC-1:0] stat_q, mask_q, mask_d;
  logic            mask_we;

  assign mask_we = we && (addr == OFS_MASK);

  always_comb begin
    mask_d = mask_q;
    if (mask_we) mask_d = wdata[NSRC-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      stat_q <= sub_irq;
      if (mask_we) mask_q <= mask_d;
    end
  end

  assign irq_out = |(stat_q & mask_q);

  always_comb begin
    hit   = (addr == OFS_STAT) || (addr == OFS_MASK);
    rdata = 8'h00;
    if (rd && addr == OFS_STAT) rdata = 8'(stat_q);
    if (rd && addr == OFS_MASK) rdata = 8'(mask_q);
  end

  p_quiet_inputs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sub_irq) == '0) |-> !irq_out);
  p_mask_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(mask_we) |-> $stable(mask_q));
endmodule

// File: rtl/sysctl_gpio.sv
module sysctl_gpio
  import sysctl_pkg::*;
#(
  parameter int unsigned PINS  = 16,
  parameter int unsigned LANES = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic            rd,
  input  logic [7:0]      addr,
  input  logic [7:0]      wdata,
  output logic [7:0]      rdata,
  output logic            hit,
  output logic [PINS-1:0] level,
  output logic [PINS-1:0] chg
);
  localparam int unsigned W = LANES * 8;

  logic [W-1:0]    dat_q, dat_d, oe_q, oe_d;
  logic [PINS-1:0] prev_q;
  logic            gp_we;

  always_comb begin
    dat_d = dat_q;
    oe_d  = oe_q;
    rdata = 8'h00;
    hit   = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (addr == 8'(OFS_DATA + 8'(i))) begin
        hit = 1'b1;
        if (we) dat_d[i*8 +: 8] = wdata;
        if (rd) rdata = dat_q[i*8 +: 8];
      end
      if (addr == 8'(OFS_OE + 8'(i))) begin
        hit = 1'b1;
        if (we) oe_d[i*8 +: 8] = wdata;
        if (rd) rdata = oe_q[i*8 +: 8];
      end
    end
  end

  assign gp_we = we & hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q  <= '0;
      oe_q   <= '0;
      prev_q <= '0;
    end else begin
      if (gp_we) begin
        dat_q <= dat_d;
        oe_q  <= oe_d;
      end
      prev_q <= level;
    end
  end

  assign level = dat_q[PINS-1:0] & oe_q[PINS-1:0];
  assign chg   = level ^ prev_q;

  p_strobe_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (chg != '0) |-> $past(gp_we));
  p_level_still_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(gp_we) |-> $stable(level));
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter logic [7:0]  REV_ID     = 8'h03,
  parameter int unsigned GPIO_PINS  = 16,
  parameter int unsigned GPIO_LANES = 3,
  parameter int unsigned IRQ_SRCS   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [7:0]           bus_addr,
  input  logic [7:0]           bus_wdata,
  output logic [7:0]           bus_rdata,
  input  logic [IRQ_SRCS-1:0]  sub_irq,
  output logic                 irq_out,
  output logic [GPIO_PINS-1:0] gpio_level,
  output logic [GPIO_PINS-1:0] gpio_chg
);
  localparam int unsigned NSTORE = 3;

  logic       rst_ns, we, rd, irq_hit, gp_hit, any_hit;
  logic [7:0] irq_rd, gp_rd, rev_rd;
  logic [7:0] st_rd  [NSTORE];
  logic       st_hit [NSTORE];

  sysctl_rstsync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ns));

  assign we = bus_sel & bus_wr;
  assign rd = bus_sel & ~bus_wr;

  sysctl_irq #(.NSRC(IRQ_SRCS)) u_irq (
    .clk(clk), .rst_n(rst_ns), .we(we), .rd(rd), .addr(bus_addr),
    .wdata(bus_wdata), .sub_irq(sub_irq), .rdata(irq_rd), .hit(irq_hit),
    .irq_out(irq_out));

  sysctl_gpio #(.PINS(GPIO_PINS), .LANES(GPIO_LANES)) u_gpio (
    .clk(clk), .rst_n(rst_ns), .we(we), .rd(rd), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(gp_rd), .hit(gp_hit), .level(gpio_level),
    .chg(gpio_chg));

  for (genvar g = 0; g < NSTORE; g++) begin : g_store
    localparam logic [7:0]  BASE_G  = (g == 0) ? OFS_CLK : (g == 1) ? OFS_PLL2 : OFS_PLL1;
    localparam int unsigned BYTES_G = (g == 0) ? CLK_BYTES : (g == 1) ? PLL2_BYTES : PLL1_BYTES;
    sysctl_lanereg #(.BYTES(BYTES_G), .BASE(BASE_G)) u_reg (
      .clk(clk), .rst_n(rst_ns), .we(we), .rd(rd), .addr(bus_addr),
      .wdata(bus_wdata), .rdata(st_rd[g]), .hit(st_hit[g]));
  end

  assign rev_rd = (rd && bus_addr == OFS_REV) ? REV_ID : 8'h00;

  always_comb begin
    bus_rdata = rev_rd | irq_rd | gp_rd;
    any_hit   = irq_hit | gp_hit | (bus_addr == OFS_REV);
    for (int i = 0; i < NSTORE; i++) begin
      bus_rdata = bus_rdata | st_rd[i];
      any_hit   = any_hit | st_hit[i];
    end
  end

  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    (rd && !any_hit) |-> (bus_rdata == 8'h00));
  p_idle_bus_zero_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    !rd |-> (bus_rdata == 8'h00));
endmodule

// File: tb/sysctl_regs_tb.sv
module sysctl_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00, bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic [7:0]  sub_irq = 8'h00;
  logic        irq_out;
  logic [15:0] gpio_level, gpio_chg;
  int checks = 0, fails = 0;
  logic [7:0] rv;

  always #4 clk = ~clk;

  sysctl_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sub_irq(sub_irq), .irq_out(irq_out), .gpio_level(gpio_level),
    .gpio_chg(gpio_chg));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic t_reset();
    chk("R1 level", gpio_level, 0);
    chk("R1 chg", gpio_chg, 0);
    chk("R1 irq", irq_out, 0);
    rd(8'h52, rv); chk("R1 mask", rv, 0);
    rd(8'h78, rv); chk("R1 data", rv, 0);
    rd(8'h7C, rv); chk("R1 oe", rv, 0);
  endtask

  task automatic t_rev();
    rd(8'h08, rv); chk("R2 rev", rv, 8'h03);
    wr(8'h08, 8'hAA);
    rd(8'h08, rv); chk("R2 rev after write", rv, 8'h03);
  endtask

  task automatic t_irq();
    @(negedge clk) sub_irq = 8'h12;
    @(negedge clk);
    rd(8'h50, rv); chk("R3 status", rv, 8'h12);
    chk("R4 irq masked off", irq_out, 0);
    wr(8'h50, 8'hFF);
    rd(8'h50, rv); chk("R3 status write ignored", rv, 8'h12);
    wr(8'h52, 8'h02);
    rd(8'h52, rv); chk("R4 mask readback", rv, 8'h02);
    chk("R4 irq on", irq_out, 1);
    wr(8'h52, 8'h01);
    chk("R4 irq no overlap", irq_out, 0);
    @(negedge clk) sub_irq = 8'h01;
    @(negedge clk);
    chk("R4 irq via line 0", irq_out, 1);
    @(negedge clk) sub_irq = 8'h00;
    @(negedge clk);
    chk("R4 irq cleared", irq_out, 0);
  endtask

  task automatic t_gpio();
    wr(8'h78, 8'hA5);
    chk("R6 data only no level", gpio_level, 0);
    chk("R7 no change no strobe", gpio_chg, 0);
    wr(8'h7C, 8'h0F);
    chk("R6 level", gpio_level, 16'h0005);
    chk("R7 strobe", gpio_chg, 16'h0005);
    @(negedge clk);
    chk("R7 strobe one cycle", gpio_chg, 0);
    wr(8'h7D, 8'hFF);
    wr(8'h79, 8'h81);
    chk("R6 upper lane", gpio_level, 16'h8105);
    chk("R7 upper strobe", gpio_chg, 16'h8100);
    wr(8'h7C, 8'hF0);
    chk("R7 mixed strobe", gpio_chg, 16'h00A5);
    chk("R6 level after oe swap", gpio_level, 16'h81A0);
    wr(8'h7A, 8'hFF); wr(8'h7E, 8'hFF);
    chk("R6 lane2 no pins", gpio_level, 16'h81A0);
    chk("R7 lane2 no strobe", gpio_chg, 0);
    rd(8'h7A, rv); chk("R5 data lane2", rv, 8'hFF);
    rd(8'h79, rv); chk("R5 data lane1", rv, 8'h81);
    rd(8'h7D, rv); chk("R5 oe lane1", rv, 8'hFF);
    rd(8'h7C, rv); chk("R5 oe lane0", rv, 8'hF0);
  endtask

  task automatic t_lanes();
    wr(8'h98, 8'h11); wr(8'h99, 8'h22);
    wr(8'h98, 8'h33);
    rd(8'h98, rv); chk("R8 clk lane0", rv, 8'h33);
    rd(8'h99, rv); chk("R8 clk lane1 kept", rv, 8'h22);
    wr(8'h9A, 8'h44);
    rd(8'h9B, rv); chk("R8 pll2 lane1", rv, 8'h00);
    rd(8'h9A, rv); chk("R8 pll2 lane0", rv, 8'h44);
    wr(8'h9C, 8'h01); wr(8'h9D, 8'h02); wr(8'h9E, 8'h03); wr(8'h9F, 8'h04);
    wr(8'h9E, 8'hEE);
    rd(8'h9C, rv); chk("R8 pll1 b0", rv, 8'h01);
    rd(8'h9D, rv); chk("R8 pll1 b1", rv, 8'h02);
    rd(8'h9E, rv); chk("R8 pll1 b2", rv, 8'hEE);
    rd(8'h9F, rv); chk("R8 pll1 b3", rv, 8'h04);
  endtask

  task automatic t_unmapped();
    wr(8'h7B, 8'hFF); wr(8'h51, 8'hFF); wr(8'hA0, 8'h55);
    rd(8'hA0, rv); chk("R9 unmapped read", rv, 0);
    rd(8'h7B, rv); chk("R9 gap read", rv, 0);
    rd(8'h52, rv); chk("R9 mask intact", rv, 8'h01);
    chk("R9 pins intact", gpio_level, 16'h81A0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        chk("R1 level in reset", gpio_level, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_rev();
        t_irq();
        t_gpio();
        t_lanes();
        t_unmapped();
      end
      begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule